// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synchronous static memory for a burst-addressed bus. An upstream sequencer presents the word address and says, on each rising edge, whether the chip is selected and whether this edge loads a new address through the processor-style strobe. The core decodes a three-level write enable into a per-byte write mask, captures the write word into an input register, and commits it to a byte-lane array one edge later. Reads are registered (one extra pipeline stage) or flow-through, chosen by a static select.

Output drive is reported as per-byte enables rather than tri-state pads. The outputs are driven only for a selected read with output enable active. Output enable acts without a clock. A write sampled on an edge turns the outputs off whatever output enable says. Each byte lane is 8 bits plus an optional parity bit, so the default word is 18 bits.

Top module: `sync_burst_sram`

## Requirements
- R1: With the chip selected and no strobe load on that edge, a low `gwe_n` writes every byte lane of `wdata` to `addr`, whatever `bwe_n` and `bw_n` are.
- R2: With `gwe_n` high and `bwe_n` low, byte lane n (bits [n*BW +: BW], BW = 9 by default) is written only when `bw_n[n]` is low. The other lanes of that word keep their old contents.
- R3: When `gwe_n` is high and either `bwe_n` is high or every `bw_n` bit is high, the edge is a read of `addr` and the memory is unchanged.
- R4: On an edge with `sel` and `strobe_ld` both high, all write enables are ignored. The edge is a read of `addr` and the memory is unchanged.
- R5: In pipeline mode (`flow_thru` = 0), the data of a read registered on edge k is driven after edge k+1. The outputs are not driven between edge k and edge k+1.
- R6: In flow-through mode (`flow_thru` = 1), the data of a read registered on edge k is driven in the cycle right after edge k. It stops being driven after the next edge that is not a read.
- R7: `drv_en` is all ones only while a read result is being presented and `oe_n` is low. Raising `oe_n` clears `drv_en` with no clock edge.
- R8: An edge that samples any write enable clears `drv_en` for the following cycle, even when `oe_n` is low and a pipelined read is still pending.
- R9: An edge with `sel` low writes nothing and starts no read. It leaves `drv_en` low in the following cycle, except for a pipelined read from the edge before it.
- R10: A read registered on the edge right after a write to the same address returns the newly written data.
- R11: The parity bit of each lane (bit 8 of lane 0 and bit 17 of lane 1 by default) is stored and returned with its lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers (not the array) |
| addr | input | AW (6) | Word address from the burst sequencer |
| sel | input | 1 | Chip selected for this edge |
| strobe_ld | input | 1 | This edge loads an address through the processor strobe |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | NB (2) | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_thru | input | 1 | Static read mode: 0 pipeline, 1 flow-through |
| wdata | input | DW (18) | Write data |
| rdata | output | DW (18) | Read data, valid while drv_en is set |
| drv_en | output | NB (2) | Per-lane output drive enables |

## Verification
The bench fills the array and then sweeps every combination of strobe load, global, byte and per-lane enables. It reads each target back, so a decode that let the strobe edge or a deselected edge write, or that merged lanes wrongly, shows up as a wrong lane in the readback. In both read modes it checks the exact cycle the drive turns on. A pipeline stage that was missing or extra would drive one cycle early or late. It also writes immediately after a read that is still in flight, which catches a design that lets a pending pipelined read drive through a write. It toggles output enable between edges, so a design that registered `oe_n` keeps driving. A read right after a write checks that the staged write has landed before it is read.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

    typedef enum logic {
        RD_PIPE = 1'b0,
        RD_FLOW = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
    parameter int NB = 2
) (
    input  logic          sel,
    input  logic          strobe_ld,
    input  logic          gwe_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic [NB-1:0] wmask,
    output logic          rd_cycle
);

    logic [NB-1:0] lane_req;

    always_comb begin
        if (!gwe_n) begin
            lane_req = '1;
        end else if (!bwe_n) begin
            lane_req = ~bw_n;
        end else begin
            lane_req = '0;
        end
        // strobe-load edges and deselected edges never write
        wmask    = (sel && !strobe_ld) ? lane_req : '0;
        rd_cycle = sel && (wmask == '0);
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int DEPTH = 64,
    parameter int NB    = 2,
    parameter int BW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * BW
) (
    input  logic          clk,
    input  logic [NB-1:0] we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                mem[waddr] <= wdata[g*BW +: BW];
            end
        end

        assign rdata[g*BW +: BW] = mem[raddr];
    end

endmodule

// File: rtl/sram_rd_stage.sv
module sram_rd_stage #(
    parameter int NB = 2,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow,
    input  logic          rd_vld,
    input  logic          wr_now,
    input  logic [DW-1:0] arr_data,
    input  logic          oe_n,
    output logic [DW-1:0] rdata,
    output logic [NB-1:0] drv_en
);

    typedef struct packed {
        logic          pv;
        logic [DW-1:0] dout;
    } rs_t;

    rs_t rs_d, rs_q;
    logic presenting;

    always_comb begin
        rs_d      = rs_q;
        rs_d.pv   = rd_vld && !wr_now;
        if (rd_vld) begin
            rs_d.dout = arr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign presenting = flow ? rd_vld : rs_q.pv;
    assign drv_en     = {NB{presenting && !oe_n}};
    assign rdata      = flow ? arr_data : rs_q.dout;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_core_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int NB       = 2,
    parameter int PAR_BITS = 1,
    localparam int BW      = 8 + PAR_BITS,
    localparam int DW      = NB * BW,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          sel,
    input  logic          strobe_ld,
    input  logic          gwe_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          oe_n,
    input  logic          flow_thru,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [NB-1:0] drv_en
);

    typedef struct packed {
        logic          wv;
        logic [AW-1:0] waddr;
        logic [NB-1:0] wmask;
        logic [DW-1:0] wdata;
        logic          rv;
        logic [AW-1:0] raddr;
    } st_t;

    st_t           st_d, st_q;
    logic [NB-1:0] wmask;
    logic          rd_cycle;
    logic [DW-1:0] arr_rdata;
    rd_mode_e      mode;

    assign mode = rd_mode_e'(flow_thru);

    sram_wr_decode #(.NB(NB)) u_dec (
        .sel       (sel),
        .strobe_ld (strobe_ld),
        .gwe_n     (gwe_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .wmask     (wmask),
        .rd_cycle  (rd_cycle)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wv    = |wmask;
        st_d.wmask = wmask;
        st_d.rv    = rd_cycle;
        if (|wmask) begin
            st_d.waddr = addr;
            st_d.wdata = wdata;
        end
        if (rd_cycle) begin
            st_d.raddr = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sram_lane_array #(.DEPTH(DEPTH), .NB(NB), .BW(BW)) u_arr (
        .clk   (clk),
        .we    (st_q.wmask & {NB{st_q.wv}}),
        .waddr (st_q.waddr),
        .wdata (st_q.wdata),
        .raddr (st_q.raddr),
        .rdata (arr_rdata)
    );

    sram_rd_stage #(.NB(NB), .DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .flow     (mode == RD_FLOW),
        .rd_vld   (st_q.rv),
        .wr_now   (|wmask),
        .arr_data (arr_rdata),
        .oe_n     (oe_n),
        .rdata    (rdata),
        .drv_en   (drv_en)
    );

    p_gw_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !strobe_ld && !gwe_n) |=> (st_q.wv && st_q.wmask == {NB{1'b1}}));

    p_lane_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !strobe_ld && gwe_n && !bwe_n) |=> (st_q.wmask == ~$past(bw_n)));

    p_strobe_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && strobe_ld) |=> (!st_q.wv && st_q.rv));

    p_wr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !strobe_ld && !gwe_n) |=> (drv_en == '0));

    p_desel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> (!st_q.wv && !st_q.rv));

endmodule

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;

    localparam int DEPTH = 64;
    localparam int AWT   = 6;
    localparam int DWT   = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AWT-1:0]  addr = '0;
    logic            sel = 1'b0;
    logic            strobe_ld = 1'b0;
    logic            gwe_n = 1'b1;
    logic            bwe_n = 1'b1;
    logic [1:0]      bw_n = 2'b11;
    logic            oe_n = 1'b0;
    logic            flow_thru = 1'b0;
    logic [DWT-1:0]  wdata = '0;
    logic [DWT-1:0]  rdata;
    logic [1:0]      drv_en;

    logic [DWT-1:0]  ref_mem [DEPTH];
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sync_burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .strobe_ld(strobe_ld),
        .gwe_n(gwe_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .flow_thru(flow_thru), .wdata(wdata), .rdata(rdata), .drv_en(drv_en)
    );

    function automatic logic [DWT-1:0] pat(input int a, input int k);
        int v;
        v = (a * 37 + k * 1117 + 5) ^ (k << 11) ^ (a << 12);
        return v[DWT-1:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (flow=%0d t=%0t)", req, act, exp, flow_thru, $time);
        end
    endtask

    // drive inputs at a falling edge, pass one rising edge, return at next falling edge
    task automatic cyc(input logic s, input logic ld, input logic g, input logic be,
                       input logic [1:0] bw, input int a, input logic [DWT-1:0] d);
        sel = s; strobe_ld = ld; gwe_n = g; bwe_n = be; bw_n = bw;
        addr = a[AWT-1:0]; wdata = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 0, '0);
    endtask

    task automatic rd_chk(input int a, input string req);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, a, '0);
        if (flow_thru) begin
            chk({req, "/R6 drive"}, 32'(drv_en), 32'h3);
            chk({req, "/R6 data"}, 32'(rdata), 32'(ref_mem[a]));
        end else begin
            chk({req, "/R5 early"}, 32'(drv_en), 32'h0);
        end
        idle();
        if (flow_thru) begin
            chk({req, "/R9 off"}, 32'(drv_en), 32'h0);
        end else begin
            chk({req, "/R5 drive"}, 32'(drv_en), 32'h3);
            chk({req, "/R5 data"}, 32'(rdata), 32'(ref_mem[a]));
        end
    endtask

    task automatic apply_wr(input int a, input logic [1:0] m, input logic [DWT-1:0] d);
        if (m[0]) ref_mem[a][8:0]  = d[8:0];
        if (m[1]) ref_mem[a][17:9] = d[17:9];
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            rst_n = 1'b0;
            flow_thru = m[0];
            sel = 1'b0; strobe_ld = 1'b0; gwe_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0;
            repeat (3) @(negedge clk);
            chk("R7 reset drive", 32'(drv_en), 32'h0);
            rst_n = 1'b1;
            @(negedge clk);

            // R1: fill with global writes; outputs must stay off (R8)
            for (int a = 0; a < DEPTH; a++) begin
                cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, a, pat(a, m));
                ref_mem[a] = pat(a, m);
                chk("R8 write edge", 32'(drv_en), 32'h0);
            end
            for (int a = 0; a < DEPTH; a++) begin
                rd_chk(a, "R1 fill readback");
            end

            // R1-R4 decode sweep: bit4 strobe, bit3 gwe_n, bit2 bwe_n, bits1:0 bw_n
            for (int c = 0; c < 32; c++) begin
                logic ld, g, be;
                logic [1:0] bw, em;
                logic [DWT-1:0] d;
                int a;
                ld = c[4]; g = c[3]; be = c[2]; bw = c[1:0];
                a  = 16 + c;
                d  = pat(a, 7 + c + m);
                em = ld ? 2'b00 : (!g ? 2'b11 : (!be ? ~bw : 2'b00));
                cyc(1'b1, ld, g, be, bw, a, d);
                if (em != 2'b00) begin
                    chk("R8 decode write edge", 32'(drv_en), 32'h0);
                end else if (flow_thru) begin
                    chk(ld ? "R4 strobe read drive" : "R3 read drive", 32'(drv_en), 32'h3);
                    chk(ld ? "R4 strobe read data" : "R3 read data", 32'(rdata), 32'(ref_mem[a]));
                end
                apply_wr(a, em, d);
                idle();
                rd_chk(a, ld ? "R4 sweep" : (!g ? "R1 sweep" : "R2/R3 sweep"));
            end

            // R9: deselected edge with write enables active
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 9, 18'h15A5A);
            chk("R9 deselect drive", 32'(drv_en), 32'h0);
            rd_chk(9, "R9 no write");

            // R10: read immediately after write to same address
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 7, 18'h2C3D1);
            ref_mem[7] = 18'h2C3D1;
            rd_chk(7, "R10 back-to-back");

            // R11: parity bits per lane
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 11, 18'h00000);
            ref_mem[11] = 18'h00000;
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 11, 18'h3FFFF);
            ref_mem[11] = 18'h3FE00;
            rd_chk(11, "R11 lane1 parity");
            chk("R11 parity bit17", 32'(ref_mem[11][17]), 32'h1);
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 11, 18'h00100);
            ref_mem[11] = 18'h3FF00;
            rd_chk(11, "R11 lane0 parity");

            // R7: asynchronous output enable
            cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 3, '0);
            if (!flow_thru) idle();
            chk("R7 drive on", 32'(drv_en), 32'h3);
            #0.5 oe_n = 1'b1;
            #0.5 chk("R7 oe high async", 32'(drv_en), 32'h0);
            oe_n = 1'b0;
            #0.5 chk("R7 oe low async", 32'(drv_en), 32'h3);
            chk("R7 data", 32'(rdata), 32'(ref_mem[3]));
            @(negedge clk);
            idle();

            // R8: write right after a read suppresses its drive
            cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 3, '0);
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 20, 18'h0ABCD);
            ref_mem[20] = 18'h0ABCD;
            chk("R8 write after read", 32'(drv_en), 32'h0);
            idle();
            chk("R8 settled", 32'(drv_en), 32'h0);
            rd_chk(20, "R8 write landed");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule